// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block sits on the host side of a write-only, three-wire serial link to a dual-channel 12-bit digital-to-analog converter. A 24-bit word arrives on a valid/ready handshake. The block pulls the active-low frame select down and waits out a setup interval. It then shifts the word out most significant bit first. Each bit is presented while the serial clock is high, so the converter can capture it on the following falling edge.

Every interval on the link is a whole number of system clock cycles taken from a parameter. These intervals are the clock high and low phases, the select-to-first-edge setup time, and the recovery gap after a frame. The gap also covers the quiet time the converter needs after the select rises, and the delay a load strobe needs after the last falling edge. Between frames, the block can also drive an active-low load strobe, which transfers latched data to the outputs, or an active-low clear strobe. Each strobe is a fixed-width pulse. Only one activity runs at a time, and the block drops ready for its whole duration.

Top module: `dac_link_writer`

## Requirements
- R1: While reset is high and in the cycle after it is released, frame select, serial clock, load strobe and clear strobe are all high, frame_ready is high and frame_done is low.
- R2: An accepted word produces exactly 24 falling serial clock edges while frame select is low. The data line carries word bit 23 at the first edge and bit 0 at the last edge.
- R3: Inside a frame, every serial clock high phase between two falling edges lasts exactly HI_CYC cycles, and every low phase lasts exactly LO_CYC cycles.
- R4: Frame select is low for exactly SETUP_CYC cycles, with the serial clock high, before the first falling edge.
- R5: The data line changes only in a cycle where the serial clock is high. It never changes in the cycle of a falling edge.
- R6: frame_done is high for exactly one cycle, the cycle in which frame select returns high after the 24th bit, and at no other time.
- R7: frame_ready is low while frame select is low. It stays low for exactly POST_CYC cycles after frame select rises. POST_CYC is the largest of GAP_CYC, IGNORE_CYC and LOAD_DLY_CYC.
- R8: An accepted load request drives the load strobe low for exactly LOAD_W_CYC cycles. The pulse starts at least LOAD_DLY_CYC cycles after the last falling serial clock edge.
- R9: An accepted clear request drives the clear strobe low for exactly CLR_W_CYC cycles.
- R10: When requests arrive together in an idle cycle, clear wins over a frame, and a frame wins over a load. A request that loses is not remembered.
- R11: Load and clear requests made while a frame, its gap or a strobe is in progress have no effect. Neither strobe ever goes low while frame select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | A word is offered |
| frame_data | input | 24 | Word to send, bit 23 first |
| frame_ready | output | 1 | Word is taken when valid and ready are both high at a clock edge |
| load_req | input | 1 | Request a load strobe pulse (taken only when idle) |
| clear_req | input | 1 | Request a clear strobe pulse (taken only when idle) |
| sclk | output | 1 | Serial clock, idles high |
| sync_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data |
| ldac_n | output | 1 | Active-low load strobe |
| clr_n | output | 1 | Active-low clear strobe |
| frame_done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The bench uses the default parameters, which are the nanosecond limits rounded up at a 5 ns system clock. These give 2-cycle clock phases, a 3-cycle setup, a 3-cycle post-frame gap, a 2-cycle load pulse and a 1-cycle clear pulse. These short intervals let a pin monitor measure every phase, gap and pulse exactly within a frame of about a hundred cycles. They also make it practical to send back-to-back frames, including all-zero, all-one and single-bit words. With a 1-cycle clear pulse, the case where the strobe rises in the very next cycle is covered.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_LOAD,
    ST_CLEAR
  } dlw_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dlw_timer.sv
// Down counter for phase lengths: loading N-1 keeps the caller in a state for N cycles.
module dlw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] init,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= init;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dlw_shifter.sv
// Holds the outgoing word and counts the bits already moved past the output.
module dlw_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb,
  output logic         last
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  word_q;
  logic [CW-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sent_q <= '0;
    end else if (load) begin
      word_q <= din;
      sent_q <= '0;
    end else if (shift) begin
      word_q <= {word_q[W-2:0], 1'b0};
      sent_q <= sent_q + 1'b1;
    end
  end

  assign msb  = word_q[W-1];
  assign last = (sent_q == CW'(W - 1));
endmodule

// File: rtl/dac_link_writer.sv
module dac_link_writer
  import dlw_pkg::*;
#(
  parameter int FRAME_W      = 24,
  parameter int HI_CYC       = 2,
  parameter int LO_CYC       = 2,
  parameter int SETUP_CYC    = 3,
  parameter int GAP_CYC      = 3,
  parameter int IGNORE_CYC   = 3,
  parameter int LOAD_DLY_CYC = 3,
  parameter int LOAD_W_CYC   = 2,
  parameter int CLR_W_CYC    = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  output logic               frame_ready,
  input  logic               load_req,
  input  logic               clear_req,
  output logic               sclk,
  output logic               sync_n,
  output logic               sdo,
  output logic               ldac_n,
  output logic               clr_n,
  output logic               frame_done
);
  localparam int POST_CYC = max3(GAP_CYC, IGNORE_CYC, LOAD_DLY_CYC);
  localparam int MAXC = max3(max3(HI_CYC, LO_CYC, SETUP_CYC), max3(POST_CYC, LOAD_W_CYC, CLR_W_CYC), 2);
  localparam int TW = $clog2(MAXC + 1);
  localparam logic [TW-1:0] HI_I    = TW'(HI_CYC - 1);
  localparam logic [TW-1:0] LO_I    = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] SETUP_I = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] POST_I  = TW'(POST_CYC - 1);
  localparam logic [TW-1:0] LOAD_I  = TW'(LOAD_W_CYC - 1);
  localparam logic [TW-1:0] CLR_I   = TW'(CLR_W_CYC - 1);

  dlw_state_t state, n_state;
  logic          tmr_start, tmr_expired;
  logic [TW-1:0] tmr_init;
  logic          sh_load, sh_shift, sh_last;
  logic          n_sclk, n_sync_n, n_ldac_n, n_clr_n, n_done;

  dlw_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .init(tmr_init), .expired(tmr_expired)
  );

  dlw_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .shift(sh_shift),
    .din(frame_data), .msb(sdo), .last(sh_last)
  );

  assign frame_ready = (state == ST_IDLE) && !clear_req;

  always_comb begin
    n_state   = state;
    tmr_start = 1'b0;
    tmr_init  = '0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    n_sclk    = sclk;
    n_sync_n  = sync_n;
    n_ldac_n  = ldac_n;
    n_clr_n   = clr_n;
    n_done    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (clear_req) begin
          n_state   = ST_CLEAR;
          n_clr_n   = 1'b0;
          tmr_start = 1'b1;
          tmr_init  = CLR_I;
        end else if (frame_valid) begin
          n_state   = ST_SETUP;
          n_sync_n  = 1'b0;
          sh_load   = 1'b1;
          tmr_start = 1'b1;
          tmr_init  = SETUP_I;
        end else if (load_req) begin
          n_state   = ST_LOAD;
          n_ldac_n  = 1'b0;
          tmr_start = 1'b1;
          tmr_init  = LOAD_I;
        end
      end
      ST_SETUP, ST_HIGH: begin
        if (tmr_expired) begin
          n_state   = ST_LOW;
          n_sclk    = 1'b0;
          tmr_start = 1'b1;
          tmr_init  = LO_I;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          n_sclk    = 1'b1;
          tmr_start = 1'b1;
          if (sh_last) begin
            n_state  = ST_GAP;
            n_sync_n = 1'b1;
            n_done   = 1'b1;
            tmr_init = POST_I;
          end else begin
            n_state  = ST_HIGH;
            sh_shift = 1'b1;
            tmr_init = HI_I;
          end
        end
      end
      ST_GAP: begin
        if (tmr_expired) n_state = ST_IDLE;
      end
      ST_LOAD: begin
        if (tmr_expired) begin
          n_state  = ST_IDLE;
          n_ldac_n = 1'b1;
        end
      end
      ST_CLEAR: begin
        if (tmr_expired) begin
          n_state = ST_IDLE;
          n_clr_n = 1'b1;
        end
      end
      default: n_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sclk       <= 1'b1;
      sync_n     <= 1'b1;
      ldac_n     <= 1'b1;
      clr_n      <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      state      <= n_state;
      sclk       <= n_sclk;
      sync_n     <= n_sync_n;
      ldac_n     <= n_ldac_n;
      clr_n      <= n_clr_n;
      frame_done <= n_done;
    end
  end

  // Falling serial clock edges belong to a frame.
  assert_fall_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> !sync_n);

  // Data is held across each falling edge.
  assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(sdo));

  // Done marks the select rising and nothing else.
  assert_done_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $rose(sync_n));

  // No new word is offered a slot mid-frame.
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> !frame_ready);

  // Strobes stay quiet during a frame.
  assert_no_strobe_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> (ldac_n && clr_n));

  // Clear and load never overlap.
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> ldac_n);

  // The link clock does not toggle outside a frame.
  assert_idle_clock_R3: assert property (@(posedge clk) disable iff (rst)
    (sync_n && $past(sync_n)) |-> sclk);
endmodule

// File: tb/sim_dac_link_writer.sv
`timescale 1ns/1ps
module sim_dac_link_writer;
  localparam int HI = 2, LO = 2, SETUP = 3, GAP = 3, IGN = 3, LDLY = 3, LDW = 2, CLW = 1;
  localparam int POST = (GAP > IGN) ? ((GAP > LDLY) ? GAP : LDLY) : ((IGN > LDLY) ? IGN : LDLY);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_valid = 1'b0;
  logic [23:0] frame_data = '0;
  logic load_req = 1'b0, clear_req = 1'b0;
  logic frame_ready, sclk, sync_n, sdo, ldac_n, clr_n, frame_done;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dac_link_writer #(
    .FRAME_W(24), .HI_CYC(HI), .LO_CYC(LO), .SETUP_CYC(SETUP), .GAP_CYC(GAP),
    .IGNORE_CYC(IGN), .LOAD_DLY_CYC(LDLY), .LOAD_W_CYC(LDW), .CLR_W_CYC(CLW)
  ) u0 (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_ready(frame_ready), .load_req(load_req), .clear_req(clear_req),
    .sclk(sclk), .sync_n(sync_n), .sdo(sdo), .ldac_n(ldac_n), .clr_n(clr_n),
    .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  // pin monitor
  logic p_sclk = 1, p_sync = 1, p_sdo = 0, p_ldac = 1, p_clr = 1;
  int sync_low_run = 0, hi_run = 0, lo_run = 0, nbits = 0, since_fall = 0;
  int gap_run = 0, ldac_run = 0, clr_run = 0;
  int frames_seen = 0, ldac_falls = 0, clr_falls = 0;
  bit in_gap = 0;
  logic [23:0] cap = '0, exp_word = '0;

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = sclk; p_sync = sync_n; p_sdo = sdo; p_ldac = ldac_n; p_clr = clr_n;
    end else begin
      if (p_sync && !sync_n) begin
        sync_low_run = 0; nbits = 0; cap = '0;
      end
      if (p_sclk && !sclk) begin
        if (nbits == 0) chk(sync_low_run == SETUP, "R4", sync_low_run, SETUP);
        else chk(hi_run == HI, "R3 high", hi_run, HI);
        cap = {cap[22:0], sdo};
        nbits++;
        since_fall = 0;
      end else if (since_fall < 1000) begin
        since_fall++;
      end
      if (!p_sclk && sclk) chk(lo_run == LO, "R3 low", lo_run, LO);
      if (sdo !== p_sdo && !sclk) chk(0, "R5", int'(sclk), 1);
      if (frame_done && !(!p_sync && sync_n)) chk(0, "R6 stray", 1, 0);
      if ((!ldac_n || !clr_n) && !sync_n) chk(0, "R11", 0, 1);
      if (in_gap) begin
        if (frame_ready) begin
          chk(gap_run == POST, "R7 gap", gap_run, POST);
          in_gap = 0;
        end else gap_run++;
      end
      if (!p_sync && sync_n) begin
        chk(frame_done === 1'b1, "R6", int'(frame_done), 1);
        chk(nbits == 24, "R2 count", nbits, 24);
        chk(cap == exp_word, "R2 data", int'(cap), int'(exp_word));
        frames_seen++;
        in_gap = 1;
        gap_run = 1;
      end
      if (p_ldac && !ldac_n) begin
        ldac_falls++;
        ldac_run = 0;
        if (frames_seen > 0) chk(since_fall >= LDLY, "R8 delay", since_fall, LDLY);
      end
      if (!p_ldac && ldac_n) chk(ldac_run == LDW, "R8 width", ldac_run, LDW);
      if (!ldac_n) ldac_run++;
      if (p_clr && !clr_n) begin
        clr_falls++;
        clr_run = 0;
      end
      if (!p_clr && clr_n) chk(clr_run == CLW, "R9 width", clr_run, CLW);
      if (!clr_n) clr_run++;
      if (!sync_n && sclk && nbits == 0) sync_low_run++;
      if (sclk) hi_run = p_sclk ? hi_run + 1 : 1;
      else lo_run = !p_sclk ? lo_run + 1 : 1;
      p_sclk = sclk; p_sync = sync_n; p_sdo = sdo; p_ldac = ldac_n; p_clr = clr_n;
    end
  end

  task automatic wait_ready;
    while (!frame_ready) tick;
  endtask

  task automatic send_frame(input logic [23:0] w);
    int n0;
    n0 = frames_seen;
    wait_ready;
    exp_word = w;
    frame_data = w;
    frame_valid = 1'b1;
    tick;
    frame_valid = 1'b0;
    chk(frame_ready == 1'b0, "R7 busy", int'(frame_ready), 0);
    while (frames_seen == n0) tick;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) tick;
    chk({sync_n, sclk, ldac_n, clr_n, frame_ready, frame_done} == 6'b111110, "R1 in reset",
        int'({sync_n, sclk, ldac_n, clr_n, frame_ready, frame_done}), 6'b111110);
    rst = 1'b0;
    tick;
    chk({sync_n, sclk, ldac_n, clr_n, frame_ready, frame_done} == 6'b111110, "R1 after",
        int'({sync_n, sclk, ldac_n, clr_n, frame_ready, frame_done}), 6'b111110);
  endtask

  task automatic t_frames;
    send_frame(24'hA5C3F0);
    send_frame(24'h000001);
    send_frame(24'h800000);
    send_frame(24'hFFFFFF);
    send_frame(24'h000000);
  endtask

  task automatic t_back_to_back;
    int n0;
    n0 = frames_seen;
    wait_ready;
    exp_word = 24'h123456;
    frame_data = 24'h123456;
    frame_valid = 1'b1;
    tick;
    frame_data = 24'h9ABCDE;
    while (frames_seen == n0) tick;
    exp_word = 24'h9ABCDE;
    while (!frame_ready) tick;
    tick;
    frame_valid = 1'b0;
    chk(sync_n == 1'b0, "R7 second frame", int'(sync_n), 0);
    while (frames_seen == n0 + 1) tick;
  endtask

  task automatic t_load_after_frame;
    int f0;
    send_frame(24'h0F0F0F);
    f0 = ldac_falls;
    load_req = 1'b1;
    while (ldac_n) tick;
    load_req = 1'b0;
    chk(ldac_falls == f0 + 1, "R8 pulse", ldac_falls - f0, 1);
    repeat (LDW + 2) tick;
    chk(ldac_n == 1'b1, "R8 end", int'(ldac_n), 1);
  endtask

  task automatic t_clear;
    int c0;
    wait_ready;
    c0 = clr_falls;
    clear_req = 1'b1;
    tick;
    clear_req = 1'b0;
    chk(clr_n == 1'b0, "R9 start", int'(clr_n), 0);
    repeat (CLW + 2) tick;
    chk(clr_falls == c0 + 1 && clr_n == 1'b1, "R9 single", clr_falls - c0, 1);
  endtask

  task automatic t_priority;
    int f0, l0;
    wait_ready;
    f0 = frames_seen;
    l0 = ldac_falls;
    clear_req = 1'b1; frame_valid = 1'b1; load_req = 1'b1; frame_data = 24'h555555;
    tick;
    clear_req = 1'b0; frame_valid = 1'b0; load_req = 1'b0;
    chk(clr_n == 1'b0 && sync_n == 1'b1, "R10 clear wins", int'({clr_n, sync_n}), 1);
    repeat (8) tick;
    chk(sync_n == 1'b1 && ldac_falls == l0 && frames_seen == f0, "R10 losers dropped",
        ldac_falls - l0, 0);
    wait_ready;
    exp_word = 24'h3C3C3C;
    frame_data = 24'h3C3C3C; frame_valid = 1'b1; load_req = 1'b1;
    tick;
    frame_valid = 1'b0; load_req = 1'b0;
    chk(sync_n == 1'b0 && ldac_n == 1'b1, "R10 frame over load", int'({sync_n, ldac_n}), 1);
    while (frames_seen == f0) tick;
    wait_ready;
    repeat (6) tick;
    chk(ldac_falls == l0, "R10 load dropped", ldac_falls - l0, 0);
  endtask

  task automatic t_busy_ignore;
    int l0, c0, n0;
    wait_ready;
    l0 = ldac_falls; c0 = clr_falls; n0 = frames_seen;
    exp_word = 24'hC0FFEE;
    frame_data = 24'hC0FFEE; frame_valid = 1'b1;
    tick;
    frame_valid = 1'b0;
    repeat (10) tick;
    load_req = 1'b1; clear_req = 1'b1;
    tick;
    load_req = 1'b0; clear_req = 1'b0;
    while (frames_seen == n0) tick;
    tick;
    load_req = 1'b1; clear_req = 1'b1;
    tick;
    load_req = 1'b0; clear_req = 1'b0;
    wait_ready;
    repeat (6) tick;
    chk(ldac_falls == l0 && clr_falls == c0, "R11 ignored", (ldac_falls - l0) + (clr_falls - c0), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_frames;
    t_back_to_back;
    t_load_after_frame;
    t_clear;
    t_priority;
    t_busy_ignore;
    repeat (5) tick;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule